// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is an 8-bit down-counting timer behind a small byte-wide register port. Software reaches three registers through a two-bit select: the count, the reload value and the control byte. A one-cycle tick input drives a prescaler, and the count drops by one each time the prescaler wraps. The timer runs either once or repeatedly. In one-shot mode it stops at zero after a short grace period. In continuous mode it reloads itself from the reload register each time it passes zero.

Writes are gated by the run state. The reload register can be written only while the timer is stopped. While the timer runs, software may only stop it. Starting the timer behaves in one of two ways, depending on whether the reload register was written since the last stop. Exactly one tick is handled per clock.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset the count reads 0x00, control reads 0x00 and the reload register reads 0xFF. The internal prescaler divisor is 1 and the prescaler remainder is -1.
- R2: The select encodings are 0 for count, 1 for reload and 2 for control. A reload write (select 1) while the run bit (control bit 1) is 0 has these effects:
  - it stores the value, with 0 meaning 256;
  - it copies the value into the count;
  - it zeroes the remainder;
  - it sets an internal loaded flag.

  Reads return the low 8 bits, so a stored 256 reads as 0x00 in both the reload and count registers.
- R3: A reload write while the run bit is 1 has no effect.
- R4: Writes to select 0 (count) or select 3 (unused) change nothing. A read of select 3 returns 0x00.
- R5: When a control write sets the run bit on a stopped timer, the divisor is chosen as follows:
  - if control bits 7:6 equal 01, the divisor is 4^(1 + control bits 5:3);
  - otherwise the divisor is 4.

  Each time the remainder reaches the divisor, the count drops by one and the remainder returns to 0.
- R6: On start, the remainder is set to -1, so the first decrement comes after divisor+1 ticks. If the loaded flag is clear, the count is first decremented by one modulo 256. If the loaded flag is set, the count is kept.
- R7: A start with control bit 0 = 0 (one-shot) that leaves the count at zero clears the run bit at once.
- R8: A control write while running changes only the run bit. Writing the run bit as 0 stops the timer and clears the loaded flag.
- R9: In continuous mode (control bit 0 = 1), a decrement below zero reloads the count with the reload value. The count always stays within 0 to 256.
- R10: In one-shot mode the timer stops once the count has gone negative, or once the count is zero and the remainder is 4 or more. On stopping, the count is forced to 0, and the run bit and the loaded flag are cleared.
- R11: A tick while stopped, or in a cycle with a write, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One cycle worth of time for the prescaler |
| sel | input | 2 | Register select: 0 count, 1 reload, 2 control, 3 unused |
| wr | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register, combinational |

## Verification
The bench builds the timer with its defaults: an 8-bit data path and a 3-bit prescale field, which allows divisors up to 65536. Directed cases use divisors of 4 and 16, covering the remainder starting at -1, continuous reload and the one-shot grace ticks. Random control bytes keep the prescale field at 0 or 1. This limits the divisor to 16 or less, so one-shot expiry and continuous reload occur many times within the run, and stops can land at any prescaler phase.

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
  parameter int DW     = 8,
  parameter int PSEL_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int CNT_W  = DW + 2;
  localparam int MAX_SH = 2 * (1 << PSEL_W);
  localparam int REM_W  = MAX_SH + 2;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int FLD_LO = 3;
  localparam int MOD_LO = FLD_LO + PSEL_W;
  localparam logic [1:0] SEL_CNT = 2'd0, SEL_LAT = 2'd1, SEL_CTL = 2'd2;

  logic [DW-1:0]           ctrl_q, ctrl_n;
  logic                    latched_q, latched_n;
  logic [DW:0]             latch_q, latch_n;
  logic signed [CNT_W-1:0] count_q, count_n;
  logic signed [REM_W-1:0] rem_q, rem_n;
  logic [SH_W-1:0]         sh_q, sh_n;

  logic                    run;
  logic [DW:0]             wval;
  logic [SH_W-1:0]         start_sh;
  logic signed [REM_W-1:0] div_v, rem_inc;
  logic signed [CNT_W-1:0] cnt_t;
  logic signed [REM_W-1:0] rem_t;

  assign run  = ctrl_q[1];
  assign wval = (wdata == '0) ? ((DW+1)'(1) << DW) : {1'b0, wdata};
  assign start_sh = (wdata[MOD_LO+1:MOD_LO] == 2'b01)
                  ? SH_W'(2 * (1 + int'(wdata[MOD_LO-1:FLD_LO])))
                  : SH_W'(2);
  assign div_v   = REM_W'(1) << sh_q;
  assign rem_inc = rem_q + REM_W'(1);

  always_comb begin
    ctrl_n    = ctrl_q;
    latched_n = latched_q;
    latch_n   = latch_q;
    count_n   = count_q;
    rem_n     = rem_q;
    sh_n      = sh_q;
    cnt_t     = count_q;
    rem_t     = rem_inc;
    if (wr) begin
      if (sel == SEL_LAT && !run) begin
        latch_n   = wval;
        count_n   = signed'({1'b0, wval});
        rem_n     = '0;
        latched_n = 1'b1;
      end else if (sel == SEL_CTL) begin
        if (run) begin
          if (!wdata[1]) begin
            ctrl_n[1] = 1'b0;
            latched_n = 1'b0;
          end
        end else begin
          ctrl_n = wdata;
          if (wdata[1]) begin
            sh_n  = start_sh;
            rem_n = '1;
            if (!latched_q) count_n = signed'({2'b00, count_q[DW-1:0] - DW'(1)});
            if (!wdata[0] && count_n == '0) ctrl_n[1] = 1'b0;
          end
        end
      end
    end else if (tick && run) begin
      if (rem_inc >= div_v) begin
        cnt_t = count_q - CNT_W'(1);
        rem_t = rem_inc - div_v;
      end
      rem_n = rem_t;
      if (ctrl_q[0]) begin
        count_n = (cnt_t < 0) ? cnt_t + signed'({1'b0, latch_q}) + CNT_W'(1) : cnt_t;
      end else if (cnt_t < 0 || (cnt_t == '0 && rem_t >= 4)) begin
        count_n   = '0;
        ctrl_n[1] = 1'b0;
        latched_n = 1'b0;
      end else begin
        count_n = cnt_t;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      latched_q <= 1'b0;
      latch_q   <= (DW+1)'((1 << DW) - 1);
      count_q   <= '0;
      rem_q     <= '1;
      sh_q      <= '0;
    end else begin
      ctrl_q    <= ctrl_n;
      latched_q <= latched_n;
      latch_q   <= latch_n;
      count_q   <= count_n;
      rem_q     <= rem_n;
      sh_q      <= sh_n;
    end
  end

  always_comb begin
    case (sel)
      SEL_CNT: rdata = count_q[DW-1:0];
      SEL_LAT: rdata = latch_q[DW-1:0];
      SEL_CTL: rdata = ctrl_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/prescaled_down_timer_chk.sv
module prescaled_down_timer_chk #(
  parameter int DW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr,
  input logic [1:0]           sel,
  input logic                 tick,
  input logic [DW-1:0]        ctrl_q,
  input logic [DW:0]          latch_q,
  input logic signed [DW+1:0] count_q
);
  // R3
  latch_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && wr && sel == 2'd1) |=> $stable(latch_q));

  // R8
  run_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && wr && sel == 2'd2) |=>
      (ctrl_q[DW-1:2] == $past(ctrl_q[DW-1:2]) && ctrl_q[0] == $past(ctrl_q[0])));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] && !wr && tick) |=> $stable(count_q) && !ctrl_q[1]);

  // R4
  count_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == 2'd0 || sel == 2'd3)) |=> $stable(count_q) && $stable(ctrl_q) && $stable(latch_q));

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q >= 0) && (count_q <= (1 << DW)));

  // R10
  oneshot_stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[1]) && !ctrl_q[0] && !$past(wr)) |-> count_q == 0);
endmodule

bind prescaled_down_timer prescaled_down_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .sel(sel), .tick(tick),
  .ctrl_q(ctrl_q), .latch_q(latch_q), .count_q(count_q)
);

// File: tb/prescaled_down_timer_tb.sv
`timescale 1ns/1ps
module prescaled_down_timer_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic [1:0] sel = 0;
  logic       wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_ctrl, m_latched, m_latch, m_count, m_rem, m_div;

  always #2.5 clk = ~clk;

  prescaled_down_timer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel),
                              .wr(wr), .wdata(wdata), .rdata(rdata));

  task automatic model_reset();
    m_ctrl = 0; m_latched = 0; m_latch = 255; m_count = 0; m_rem = -1; m_div = 1;
  endtask

  task automatic model_step(bit w, int s, int d, bit t);
    if (w) begin
      if (s == 1 && !m_ctrl[1]) begin
        m_latch = (d == 0) ? 256 : d; m_count = m_latch; m_rem = 0; m_latched = 1;
      end else if (s == 2) begin
        if (m_ctrl[1]) begin
          if (!d[1]) begin m_ctrl = m_ctrl & ~2; m_latched = 0; end
        end else begin
          m_ctrl = d;
          if (d[1]) begin
            m_div = (d[7:6] == 2'b01) ? (1 << (2 * (1 + d[5:3]))) : 4;
            if (!m_latched) m_count = (m_count - 1) & 255;
            m_rem = -1;
            if (!d[0] && m_count == 0) m_ctrl = m_ctrl & ~2;
          end
        end
      end
    end else if (t && m_ctrl[1]) begin
      m_rem = m_rem + 1;
      if (m_rem >= m_div) begin m_count = m_count - 1; m_rem = m_rem - m_div; end
      if (m_ctrl[0]) begin
        while (m_count < 0) m_count = m_count + m_latch + 1;
      end else if (m_count < 0 || (m_count == 0 && m_rem >= 4)) begin
        m_count = 0; m_ctrl = m_ctrl & ~2; m_latched = 0;
      end
    end
  endtask

  function automatic int model_read(int s);
    case (s)
      0: return m_count & 255;
      1: return m_latch & 255;
      2: return m_ctrl;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(bit w, int s, int d, bit t);
    wr = w; sel = 2'(s); wdata = 8'(d); tick = t;
    @(posedge clk);
    model_step(w, s, d, t);
    @(negedge clk);
    wr = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
  endtask

  task automatic chk(int s, int exp, string tag);
    wr = 0; tick = 0; sel = 2'(s);
    #1;
    checks++;
    if (rdata !== 8'(exp)) begin
      fails++;
      $display("FAIL %s sel=%0d actual=%02h expected=%02h", tag, s, rdata, 8'(exp));
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(0, 8'h00, "R1"); chk(1, 8'hFF, "R1"); chk(2, 8'h00, "R1");
    // R4 ignored writes
    cyc(1, 0, 8'h55, 0); chk(0, 8'h00, "R4");
    cyc(1, 3, 8'hAA, 0); chk(3, 8'h00, "R4"); chk(2, 8'h00, "R4");
    // R6 start without reload write, R5 default divisor
    cyc(1, 2, 8'h02, 0); chk(0, 8'hFF, "R6"); chk(2, 8'h02, "R6");
    ticks(4); chk(0, 8'hFF, "R6");
    ticks(1); chk(0, 8'hFE, "R5");
    // R8 running control write only run bit
    cyc(1, 2, 8'hFE, 0); chk(2, 8'h02, "R8");
    cyc(1, 2, 8'h00, 0); chk(2, 8'h00, "R8"); chk(0, 8'hFE, "R8");
    // R3 reload write while running
    cyc(1, 2, 8'h02, 0); chk(0, 8'hFD, "R8");
    cyc(1, 1, 8'h10, 0); chk(1, 8'hFF, "R3"); chk(0, 8'hFD, "R3");
    cyc(1, 2, 8'h00, 0);
    // R2 zero means 256
    cyc(1, 1, 8'h00, 0); chk(1, 8'h00, "R2"); chk(0, 8'h00, "R2");
    cyc(1, 2, 8'h03, 0); chk(0, 8'h00, "R6");
    ticks(5); chk(0, 8'hFF, "R2");
    cyc(1, 2, 8'h00, 0);
    // R7 one-shot start at zero
    cyc(1, 1, 8'h02, 0); cyc(1, 2, 8'h02, 0); ticks(5); chk(0, 8'h01, "R7");
    cyc(1, 2, 8'h00, 0);
    cyc(1, 2, 8'h02, 0); chk(2, 8'h00, "R7"); chk(0, 8'h00, "R7");
    ticks(3); chk(0, 8'h00, "R11"); chk(2, 8'h00, "R11");
    // R9 continuous reload
    cyc(1, 1, 8'h02, 0); cyc(1, 2, 8'h03, 0);
    ticks(9); chk(0, 8'h00, "R9");
    ticks(4); chk(0, 8'h02, "R9"); chk(2, 8'h03, "R9");
    cyc(1, 2, 8'h00, 0);
    // R10 one-shot grace
    cyc(1, 1, 8'h01, 0); cyc(1, 2, 8'h02, 0);
    ticks(5); chk(0, 8'h00, "R10"); chk(2, 8'h02, "R10");
    ticks(3); chk(2, 8'h02, "R10");
    ticks(1); chk(2, 8'h00, "R10"); chk(0, 8'h00, "R10");
    cyc(1, 2, 8'h02, 0); chk(0, 8'hFF, "R10");
    cyc(1, 2, 8'h00, 0);
    // R5 divisor field
    cyc(1, 1, 8'h05, 0); cyc(1, 2, 8'h4A, 0);
    ticks(16); chk(0, 8'h05, "R5");
    ticks(1); chk(0, 8'h04, "R5");
    cyc(1, 2, 8'h00, 0);
    cyc(1, 1, 8'h05, 0); cyc(1, 2, 8'h8A, 0);
    ticks(4); chk(0, 8'h05, "R5");
    ticks(1); chk(0, 8'h04, "R5");
    cyc(1, 2, 8'h00, 0);
    // R11 tick during a write cycle
    cyc(1, 1, 8'h03, 0); cyc(1, 2, 8'h02, 0);
    for (int i = 0; i < 5; i++) cyc(1, 2, 8'h02, 1);
    chk(0, 8'h03, "R11"); chk(2, 8'h02, "R11");
    ticks(4); chk(0, 8'h03, "R11");
    cyc(1, 2, 8'h00, 0);
    // random phase against model
    void'($urandom(32'h1BAD5EED));
    for (int n = 0; n < 3000; n++) begin
      int r, s, d;
      bit w, t;
      r = $urandom_range(0, 99);
      w = (r < 12);
      t = ($urandom_range(0, 9) < 8);
      s = $urandom_range(0, 3);
      if (w && $urandom_range(0, 1) == 1) s = $urandom_range(1, 2);
      d = $urandom_range(0, 255);
      if (s == 1 && $urandom_range(0, 3) != 0) d = d & 8'h0F;
      if (d[5:4] != 2'b00) d = d & 8'hCF;
      cyc(w, s, d, t);
      chk(0, model_read(0), "R9");
      chk(1, model_read(1), "R2");
      chk(2, model_read(2), "R8");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule